// File: doc/BRIEF.md
# Raster Video DMA Timing Generator

This block produces the display timing for a monochrome raster screen whose fetches are served by a processor's DMA response cycles. All timing is counted in processor machine cycles. A machine-cycle strobe advances a cycle counter within the scan line, and a line counter within the field. At a fixed lead before the first active line, the block pulls an active-low interrupt request so that software can prepare the fetch pointer. On every active line it holds an active-low DMA request for a burst of byte fetches. A status flag tells software whether more active lines follow the current one.

When the processor acknowledges a DMA cycle, it drives the DMA state code on its state lines. The byte on the data bus in that cycle is captured and shifted out as eight pixels, most significant bit first. Each shift happens on a pixel clock enable that runs at eight times the machine-cycle rate. A display-enable input silences the interrupt, the DMA request and the status flag. The line phase is kept by a four-state machine. BLANK covers non-active lines. LEAD covers the idle cycles before the fetch window. FETCH covers the DMA window. TAIL covers the idle cycles after it. The transitions are:

- BLANK to LEAD at cycle 0 of an active line.
- LEAD to FETCH when the cycle reaches the lead length.
- FETCH to TAIL when the burst length has elapsed.
- TAIL to LEAD at the next line start if that line is active, TAIL to BLANK otherwise.
- Any state to BLANK at a strobe taken while display is disabled.

With the default parameters, a line is 14 cycles and a field is 262 lines (3668 cycles). The active area is 128 lines, each split into 2 idle cycles, 8 fetch cycles and 4 idle cycles. The interrupt leads the first active line by 29 cycles.

Top module: `raster_dma_timer`

## Requirements
- R1: The position advances by one machine cycle only on a clock with `cyc_en` high. A line spans CYC_PER_LINE strobes and a field spans LINES_PER_FIELD lines. After a field wraps, the same output pattern repeats from position 0.
- R2: With display enabled, `dma_n` is low exactly at cycles PRE_CYC through PRE_CYC+DMA_CYC-1 of lines ACTIVE_FIRST through ACTIVE_FIRST+ACTIVE_LINES-1. Each burst is DMA_CYC consecutive strobes long, and `dma_n` is high everywhere else.
- R3: With display enabled, `int_n` falls at field position ACTIVE_FIRST*CYC_PER_LINE-INT_LEAD, measured in cycles from the start of line 0. It stays low for exactly CYC_PER_LINE strobes and then returns high.
- R4: With display enabled, `rows_n` is low on lines ACTIVE_FIRST through ACTIVE_FIRST+ACTIVE_LINES-2, and high on the last active line and on all other lines.
- R5: While `disp_en` is low, `int_n`, `dma_n` and `rows_n` are all high. An interrupt point passed while disabled raises no request.
- R6: A strobe taken with `sc` equal to 2'b10 (the DMA state code) loads `dbus` into the pixel register. After that edge, `pix` shows bit 7 of the byte.
- R7: Each `pix_en` pulse shifts the pixel register one place toward the most significant bit, filling with 0. After k pulses, `pix` shows bit 7-k. After 8 pulses, `pix` is 0.
- R8: A strobe with any other `sc` code leaves the pixel register unchanged, whatever `dbus` carries.
- R9: After reset, the position is line 0 cycle 0, `int_n`, `dma_n` and `rows_n` are high, and `pix` is 0.
- R10: Between strobes, with `disp_en` steady, `int_n`, `dma_n` and `rows_n` hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Machine-cycle strobe |
| pix_en | input | 1 | Pixel clock enable (eight per machine cycle) |
| disp_en | input | 1 | Display enable; low silences all requests |
| sc | input | 2 | Processor state code; 2'b10 marks a DMA cycle |
| dbus | input | 8 | Processor data bus |
| int_n | output | 1 | Active-low interrupt request |
| dma_n | output | 1 | Active-low DMA-out request |
| rows_n | output | 1 | Low while more active lines follow |
| pix | output | 1 | Serial pixel output |

## Verification
The bench builds the block with a 20-line field and 8 active lines starting at line 6. It keeps the real 14-cycle line, the 2/8/4 line split and the 29-cycle lead. With this configuration the interrupt falls at line 3 cycle 13, so the lead crosses a line boundary. A few hundred strobes then cover every field position. The bench sweeps three whole fields: enabled, disabled, then enabled again. At each position it compares the outputs with an arithmetic model of position and enable. In every DMA cycle it drives a different byte and walks all eight pixels out. In every other cycle it drives an all-ones bus under a non-DMA state code, to show that the bus is ignored.

// File: rtl/rdt_pkg.sv
package rdt_pkg;

    typedef enum logic [1:0] {
        PH_BLANK,
        PH_LEAD,
        PH_FETCH,
        PH_TAIL
    } phase_t;

    localparam logic [1:0] SC_DMA = 2'b10;

endpackage

// File: rtl/rdt_pos_counter.sv
module rdt_pos_counter #(
    parameter int CYC_PER_LINE    = 14,
    parameter int LINES_PER_FIELD = 262,
    localparam int CW = $clog2(CYC_PER_LINE),
    localparam int LW = $clog2(LINES_PER_FIELD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    output logic [LW-1:0] line_q,
    output logic [CW-1:0] cyc_nx,
    output logic [LW-1:0] line_nx
);

    logic [CW-1:0] cyc_q;

    always_comb begin
        cyc_nx  = cyc_q;
        line_nx = line_q;
        if (step) begin
            if (cyc_q == CW'(CYC_PER_LINE - 1)) begin
                cyc_nx  = '0;
                line_nx = (line_q == LW'(LINES_PER_FIELD - 1)) ? '0 : line_q + 1'b1;
            end else begin
                cyc_nx = cyc_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q  <= '0;
            line_q <= '0;
        end else begin
            cyc_q  <= cyc_nx;
            line_q <= line_nx;
        end
    end

endmodule

// File: rtl/rdt_line_fsm.sv
module rdt_line_fsm
    import rdt_pkg::*;
#(
    parameter int CYC_PER_LINE    = 14,
    parameter int LINES_PER_FIELD = 262,
    parameter int ACTIVE_FIRST    = 80,
    parameter int ACTIVE_LINES    = 128,
    parameter int PRE_CYC         = 2,
    parameter int DMA_CYC         = 8,
    localparam int CW = $clog2(CYC_PER_LINE),
    localparam int LW = $clog2(LINES_PER_FIELD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          en,
    input  logic [CW-1:0] cyc_nx,
    input  logic [LW-1:0] line_nx,
    input  logic [LW-1:0] line_q,
    output logic          fetch,
    output logic          more_rows
);

    phase_t st_q, st_d;
    logic   act_nx;

    assign act_nx = (int'(line_nx) >= ACTIVE_FIRST) &&
                    (int'(line_nx) < ACTIVE_FIRST + ACTIVE_LINES);

    always_comb begin
        st_d = st_q;
        if (step) begin
            if (!en) begin
                st_d = PH_BLANK;
            end else begin
                unique case (st_q)
                    PH_BLANK: if (act_nx && cyc_nx == '0) st_d = PH_LEAD;
                    PH_LEAD:  if (cyc_nx == CW'(PRE_CYC)) st_d = PH_FETCH;
                    PH_FETCH: if (cyc_nx == CW'(PRE_CYC + DMA_CYC)) st_d = PH_TAIL;
                    PH_TAIL:  if (cyc_nx == '0) st_d = act_nx ? PH_LEAD : PH_BLANK;
                    default:  st_d = PH_BLANK;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= PH_BLANK;
        else        st_q <= st_d;
    end

    always_comb begin
        fetch     = (st_q == PH_FETCH);
        more_rows = (int'(line_q) >= ACTIVE_FIRST) &&
                    (int'(line_q) < ACTIVE_FIRST + ACTIVE_LINES - 1);
    end

endmodule

// File: rtl/rdt_int_gen.sv
module rdt_int_gen #(
    parameter int CYC_PER_LINE    = 14,
    parameter int LINES_PER_FIELD = 262,
    parameter int INT_LINE        = 77,
    parameter int INT_CYC         = 13,
    localparam int CW = $clog2(CYC_PER_LINE),
    localparam int LW = $clog2(LINES_PER_FIELD),
    localparam int NW = $clog2(CYC_PER_LINE + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic          en,
    input  logic [CW-1:0] cyc_nx,
    input  logic [LW-1:0] line_nx,
    output logic          irq_on
);

    logic [NW-1:0] left_q;
    logic          hit;

    assign hit = (line_nx == LW'(INT_LINE)) && (cyc_nx == CW'(INT_CYC));

    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            left_q <= '0;
        end else if (step) begin
            if (hit)               left_q <= NW'(CYC_PER_LINE);
            else if (left_q != '0) left_q <= left_q - 1'b1;
        end
    end

    assign irq_on = (left_q != '0);

endmodule

// File: rtl/rdt_pix_shift.sv
module rdt_pix_shift
    import rdt_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  logic              pix_en,
    input  logic [1:0]        sc,
    input  logic [BYTE_W-1:0] dbus,
    output logic              pix
);

    logic [BYTE_W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (!rst_n)                     sr_q <= '0;
        else if (step && sc == SC_DMA)  sr_q <= dbus;
        else if (pix_en)                sr_q <= {sr_q[BYTE_W-2:0], 1'b0};
    end

    assign pix = sr_q[BYTE_W-1];

endmodule

// File: rtl/raster_dma_timer.sv
module raster_dma_timer #(
    parameter int CYC_PER_LINE    = 14,
    parameter int LINES_PER_FIELD = 262,
    parameter int ACTIVE_FIRST    = 80,
    parameter int ACTIVE_LINES    = 128,
    parameter int PRE_CYC         = 2,
    parameter int DMA_CYC         = 8,
    parameter int INT_LEAD        = 29,
    parameter int BYTE_W          = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              pix_en,
    input  logic              disp_en,
    input  logic [1:0]        sc,
    input  logic [BYTE_W-1:0] dbus,
    output logic              int_n,
    output logic              dma_n,
    output logic              rows_n,
    output logic              pix
);

    localparam int CW       = $clog2(CYC_PER_LINE);
    localparam int LW       = $clog2(LINES_PER_FIELD);
    localparam int INT_POS  = ACTIVE_FIRST * CYC_PER_LINE - INT_LEAD;
    localparam int INT_LINE = INT_POS / CYC_PER_LINE;
    localparam int INT_CYC  = INT_POS % CYC_PER_LINE;

    logic [LW-1:0] line_q, line_nx;
    logic [CW-1:0] cyc_nx;
    logic          fetch, more_rows, irq_on;

    rdt_pos_counter #(
        .CYC_PER_LINE(CYC_PER_LINE), .LINES_PER_FIELD(LINES_PER_FIELD)
    ) u_pos (
        .clk(clk), .rst_n(rst_n), .step(cyc_en),
        .line_q(line_q), .cyc_nx(cyc_nx), .line_nx(line_nx)
    );

    rdt_line_fsm #(
        .CYC_PER_LINE(CYC_PER_LINE), .LINES_PER_FIELD(LINES_PER_FIELD),
        .ACTIVE_FIRST(ACTIVE_FIRST), .ACTIVE_LINES(ACTIVE_LINES),
        .PRE_CYC(PRE_CYC), .DMA_CYC(DMA_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .step(cyc_en), .en(disp_en),
        .cyc_nx(cyc_nx), .line_nx(line_nx), .line_q(line_q),
        .fetch(fetch), .more_rows(more_rows)
    );

    rdt_int_gen #(
        .CYC_PER_LINE(CYC_PER_LINE), .LINES_PER_FIELD(LINES_PER_FIELD),
        .INT_LINE(INT_LINE), .INT_CYC(INT_CYC)
    ) u_int (
        .clk(clk), .rst_n(rst_n), .step(cyc_en), .en(disp_en),
        .cyc_nx(cyc_nx), .line_nx(line_nx), .irq_on(irq_on)
    );

    rdt_pix_shift #(.BYTE_W(BYTE_W)) u_pix (
        .clk(clk), .rst_n(rst_n), .step(cyc_en), .pix_en(pix_en),
        .sc(sc), .dbus(dbus), .pix(pix)
    );

    assign int_n  = !(irq_on && disp_en);
    assign dma_n  = !(fetch && disp_en);
    assign rows_n = !(more_rows && disp_en);

endmodule

// File: rtl/raster_dma_timer_chk.sv
module raster_dma_timer_chk #(
    parameter int CYC_PER_LINE = 14,
    parameter int DMA_CYC      = 8
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cyc_en,
    input logic       disp_en,
    input logic [1:0] sc,
    input logic       dbus_msb,
    input logic       int_n,
    input logic       dma_n,
    input logic       rows_n,
    input logic       pix
);

    logic [15:0] dma_run, int_run;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dma_run <= '0;
            int_run <= '0;
        end else if (cyc_en) begin
            dma_run <= dma_n ? '0 : dma_run + 1'b1;
            int_run <= int_n ? '0 : int_run + 1'b1;
        end
    end

    AST_DMA_BURST_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        dma_run <= 16'(DMA_CYC)); // R2
    AST_DMA_BURST_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(dma_n) && disp_en && $past(disp_en)) |-> dma_run == 16'(DMA_CYC)); // R2
    AST_INT_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        int_run <= 16'(CYC_PER_LINE)); // R3
    AST_DISABLED_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !disp_en |-> (int_n && dma_n && rows_n)); // R5
    AST_PIX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_en && sc == 2'b10) |=> pix == $past(dbus_msb)); // R6
    AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!cyc_en) && disp_en && $past(disp_en)) |->
        ($stable(int_n) && $stable(dma_n) && $stable(rows_n))); // R10

endmodule

bind raster_dma_timer raster_dma_timer_chk #(
    .CYC_PER_LINE(CYC_PER_LINE), .DMA_CYC(DMA_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .disp_en(disp_en), .sc(sc),
    .dbus_msb(dbus[BYTE_W-1]), .int_n(int_n), .dma_n(dma_n), .rows_n(rows_n),
    .pix(pix)
);

// File: tb/test_raster_dma_timer.sv
`timescale 1ns/1ps
module test_raster_dma_timer;

    localparam int CPL   = 14;
    localparam int LPF   = 20;
    localparam int AF    = 6;
    localparam int AL    = 8;
    localparam int PRE   = 2;
    localparam int DMA   = 8;
    localparam int LEAD  = 29;
    localparam int FIELD = CPL * LPF;
    localparam int INTP  = AF * CPL - LEAD;

    logic clk = 1'b0;
    logic rst_n, cyc_en, pix_en, disp_en;
    logic [1:0] sc;
    logic [7:0] dbus;
    logic int_n, dma_n, rows_n, pix;

    int n_cmp = 0;
    int n_bad = 0;
    int p;
    bit en;

    always #2.5 clk = ~clk;

    raster_dma_timer #(
        .CYC_PER_LINE(CPL), .LINES_PER_FIELD(LPF), .ACTIVE_FIRST(AF),
        .ACTIVE_LINES(AL), .PRE_CYC(PRE), .DMA_CYC(DMA), .INT_LEAD(LEAD), .BYTE_W(8)
    ) i_raster_dma_timer (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .pix_en(pix_en),
        .disp_en(disp_en), .sc(sc), .dbus(dbus),
        .int_n(int_n), .dma_n(dma_n), .rows_n(rows_n), .pix(pix)
    );

    function automatic bit e_dma(int q, bit e);
        int ln = q / CPL;
        int c  = q % CPL;
        return e && ln >= AF && ln < AF + AL && c >= PRE && c < PRE + DMA;
    endfunction

    function automatic bit e_int(int q, bit e);
        return e && q >= INTP && q < INTP + CPL;
    endfunction

    function automatic bit e_rows(int q, bit e);
        int ln = q / CPL;
        return e && ln >= AF && ln < AF + AL - 1;
    endfunction

    task automatic chk(input logic act, input logic exp, input string tag);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s at pos %0d: got %0b expected %0b", tag, p, act, exp);
        end
    endtask

    task automatic strobe(input logic [1:0] code, input logic [7:0] d);
        @(negedge clk);
        cyc_en = 1'b1; sc = code; dbus = d;
        @(negedge clk);
        cyc_en = 1'b0; sc = 2'b00; dbus = 8'h00;
    endtask

    task automatic pulse_pix();
        @(negedge clk);
        pix_en = 1'b1;
        @(negedge clk);
        pix_en = 1'b0;
    endtask

    task automatic chk_lines(input string sfx);
        chk(dma_n,  !e_dma(p, en),  {"R2 dma_n", sfx});
        chk(int_n,  !e_int(p, en),  {"R3 int_n", sfx});
        chk(rows_n, !e_rows(p, en), {"R4 rows_n", sfx});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R1 watchdog expired: got hang expected finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cyc_en = 1'b0; pix_en = 1'b0; disp_en = 1'b1;
        sc = 2'b00; dbus = 8'h00;
        p = 0; en = 1'b1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(int_n, 1'b1, "R9 reset int_n");
        chk(dma_n, 1'b1, "R9 reset dma_n");
        chk(rows_n, 1'b1, "R9 reset rows_n");
        chk(pix, 1'b0, "R9 reset pix");

        for (int f = 0; f < 3; f++) begin
            en = (f != 1);
            disp_en = en;
            @(negedge clk);
            for (int s = 0; s < FIELD; s++) begin
                bit d_now;
                logic [7:0] bv;
                d_now = e_dma(p, en);
                bv = 8'((p * 53 + f * 7) ^ 8'hA5);
                if (d_now) strobe(2'b10, bv);
                else       strobe(2'b01, 8'hFF);
                p = (p + 1) % FIELD;
                if (f == 2) begin
                    chk(dma_n, !e_dma(p, en), "R1 repeat dma_n");
                    chk(int_n, !e_int(p, en), "R1 repeat int_n");
                end
                if (!en) chk(int_n & dma_n & rows_n, 1'b1, "R5 disabled quiet");
                chk_lines("");
                if (d_now) begin
                    chk(pix, bv[7], "R6 first pixel");
                    for (int k = 1; k < 8; k++) begin
                        pulse_pix();
                        chk(pix, bv[7-k], "R7 shifted pixel");
                    end
                    pulse_pix();
                    chk(pix, 1'b0, "R7 zero fill");
                end else begin
                    chk(pix, 1'b0, "R8 non-DMA code ignored");
                    pulse_pix();
                end
                chk_lines(" R10 hold");
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule